// File: doc/BRIEF.md
# Paired Lock-Step Timer Output Stage

This block sits behind a group of timer channels and turns each channel's internal output flag into a pin drive. Channels are grouped in fixed neighbouring pairs. When a channel's cross-check is switched on, its flag is compared on every clock with the flag of its partner. Any disagreement latches a sticky miscompare bit, and that bit holds the channel's drive at its inactive level until software clears it. A software force strobe can load a chosen value into a channel's flag. A per-channel polarity bit inverts the level that reaches the pin, and a per-channel enable decides whether the channel drives its pin or leaves it as an input.

Each channel also reads back one pin of the group as its secondary input. The read path takes the driven value when that pin is an output and the external value otherwise. It applies an optional inversion, passes the bit through a two-flop synchronizer and then through a three-sample majority filter.

Top module: `redundant_out_stage`

## Requirements
- R1: Channels are cross-checked only with their fixed partner, the channel whose index differs in bit 0 (0 with 1, 2 with 3, 4 with 5). Flags of channels in different pairs are never compared.
- R2: While `red_en[i]` is 0, `miscmp[i]` never goes from 0 to 1, whatever the flags do.
- R3: While `red_en[i]` is 1, a difference between the flag of channel i and its partner's flag at a clock edge makes `miscmp[i]` read 1 after that edge.
- R4: While `miscmp[i]` is 1, the channel's level before polarity is 0, so `pin_out[i]` equals `inv_out[i]`.
- R5: While `miscmp[i]` is 0, `pin_out[i]` equals the channel flag XOR `inv_out[i]`. The flag is the value of `flag_in[i]` sampled at the previous clock edge.
- R6: `pin_oe[i]` follows `oe_en[i]`. With `oe_en[i]`=1, every channel reading pin i sees `pin_out[i]`. With `oe_en[i]`=0, it sees `pin_in[i]`.
- R7: A clock edge with `force_cmd[i]`=1 loads `force_val[i]` into the channel flag instead of `flag_in[i]`.
- R8: `miscmp[i]` is sticky. It is cleared at a clock edge with `reg_wr`=1 and `clr_mask[i]`=1. A mismatch seen at the same edge takes priority and keeps it set. A 0 in the mask has no effect.
- R9: `in_sync[i]` is the majority of three consecutive samples of (selected pin XOR `inv_in[i]`), taken behind a two-flop synchronizer. A change on the selected pin therefore appears 4 edges after the first edge that samples it. A one-sample pulse never appears. The pin is chosen by `sec_sel[i*3 +: 3]`, and a value of 6 or 7 selects a constant 0.
- R10: After reset all flags, miscompare bits and filter stages are 0, so `pin_out`, `miscmp` and `in_sync` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_in | input | NCH | Next flag value from each channel's compare logic |
| force_cmd | input | NCH | Software force strobe per channel |
| force_val | input | NCH | Value loaded by a force strobe |
| red_en | input | NCH | Cross-check enable per channel |
| inv_out | input | NCH | Output polarity invert per channel |
| oe_en | input | NCH | 1: channel drives its pin; 0: pin is an input |
| inv_in | input | NCH | Secondary input invert per channel |
| sec_sel | input | NCH*3 | Per channel, index of the pin read as secondary input |
| reg_wr | input | 1 | Write strobe for the miscompare clear mask |
| clr_mask | input | NCH | Write-1-to-clear mask for the miscompare bits |
| pin_in | input | NCH | External pin values |
| pin_out | output | NCH | Pin drive level |
| pin_oe | output | NCH | Pin drive enable |
| miscmp | output | NCH | Sticky miscompare bits |
| in_sync | output | NCH | Filtered secondary input readback |

## Verification
On every cycle, the checker confirms several things. A miscompare bit rises only when its channel's check is enabled. A partner mismatch sets the bit on the next edge. The bit stays set unless a clear arrives with no mismatch present. The pin level equals the gated flag with polarity applied, and a force strobe loads its value. The bench scenarios show how the read path behaves over time: the four-edge latency through the synchronizer and majority filter, the rejection of a single-sample pulse, and the loop-back of a driven pin to other channels. They also cover the priority of a set over a clear at the same edge and the fact that no channel is ever compared across pairs.

// File: rtl/ros_pkg.sv
package ros_pkg;

  // Level placed on the pin: flag gated by miscompare, then polarity.
  function automatic logic drive_level(logic flag, logic bad, logic inv);
    return (flag & ~bad) ^ inv;
  endfunction

  // Two-of-three vote.
  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/ros_flag_pair.sv
module ros_flag_pair (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] flag_in,
  input  logic [1:0] force_cmd,
  input  logic [1:0] force_val,
  input  logic [1:0] red_en,
  input  logic [1:0] clr_hit,
  output logic [1:0] oflag,
  output logic [1:0] miscmp
);

  logic       differ_w;
  logic [1:0] set_w;
  logic [1:0] flag_nxt;

  assign differ_w = oflag[0] ^ oflag[1];
  assign set_w    = red_en & {2{differ_w}};

  for (genvar k = 0; k < 2; k++) begin : g_sel
    assign flag_nxt[k] = force_cmd[k] ? force_val[k] : flag_in[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oflag  <= '0;
      miscmp <= '0;
    end else begin
      oflag  <= flag_nxt;
      miscmp <= set_w | (miscmp & ~clr_hit);
    end
  end

endmodule

// File: rtl/ros_in_filter.sv
module ros_in_filter #(
  parameter int SYNC_STAGES = 2,
  localparam int VOTES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTES-1:0]       hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[VOTES-2:0], sync_q[SYNC_STAGES-1]};
    end
  end

  assign dout = ros_pkg::maj3(hist_q[0], hist_q[1], hist_q[2]);

endmodule

// File: rtl/redundant_out_stage.sv
module redundant_out_stage #(
  parameter int NCH = 6,
  localparam int SELW = $clog2(NCH),
  localparam int NPAIR = NCH / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     flag_in,
  input  logic [NCH-1:0]     force_cmd,
  input  logic [NCH-1:0]     force_val,
  input  logic [NCH-1:0]     red_en,
  input  logic [NCH-1:0]     inv_out,
  input  logic [NCH-1:0]     oe_en,
  input  logic [NCH-1:0]     inv_in,
  input  logic [NCH*SELW-1:0] sec_sel,
  input  logic               reg_wr,
  input  logic [NCH-1:0]     clr_mask,
  input  logic [NCH-1:0]     pin_in,
  output logic [NCH-1:0]     pin_out,
  output logic [NCH-1:0]     pin_oe,
  output logic [NCH-1:0]     miscmp,
  output logic [NCH-1:0]     in_sync
);

  logic [NCH-1:0] oflag_w;   // channel flags, visible to the checker
  logic [NCH-1:0] clr_hit_w;
  logic [NCH-1:0] pin_val_w; // value every reader of a pin observes

  assign clr_hit_w = clr_mask & {NCH{reg_wr}};
  assign pin_oe    = oe_en;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    ros_flag_pair u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .flag_in   (flag_in[2*p +: 2]),
      .force_cmd (force_cmd[2*p +: 2]),
      .force_val (force_val[2*p +: 2]),
      .red_en    (red_en[2*p +: 2]),
      .clr_hit   (clr_hit_w[2*p +: 2]),
      .oflag     (oflag_w[2*p +: 2]),
      .miscmp    (miscmp[2*p +: 2])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_bit;

    assign pin_out[i]   = ros_pkg::drive_level(oflag_w[i], miscmp[i], inv_out[i]);
    assign pin_val_w[i] = oe_en[i] ? pin_out[i] : pin_in[i];

    always_comb begin
      sel_bit = 1'b0;
      for (int j = 0; j < NCH; j++) begin
        if (sec_sel[i*SELW +: SELW] == SELW'(j)) sel_bit = pin_val_w[j];
      end
    end

    ros_in_filter #(.SYNC_STAGES(2)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sel_bit ^ inv_in[i]),
      .dout  (in_sync[i])
    );
  end

endmodule

// File: rtl/ros_checker.sv
module ros_checker #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] red_en,
  input logic [NCH-1:0] inv_out,
  input logic [NCH-1:0] force_cmd,
  input logic [NCH-1:0] force_val,
  input logic           reg_wr,
  input logic [NCH-1:0] clr_mask,
  input logic [NCH-1:0] oflag_w,
  input logic [NCH-1:0] miscmp,
  input logic [NCH-1:0] pin_out
);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    localparam int P = i ^ 1;

    // R2
    a_r2_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miscmp[i]) |-> $past(red_en[i]));

    // R3 and R1: partner mismatch sets the bit on the next edge
    a_r3_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (red_en[i] && (oflag_w[i] != oflag_w[P])) |=> miscmp[i]);

    // R4
    a_r4_gated_inactive: assert property (@(posedge clk) disable iff (!rst_n)
      miscmp[i] |-> (pin_out[i] == inv_out[i]));

    // R5
    a_r5_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      !miscmp[i] |-> (pin_out[i] == (oflag_w[i] ^ inv_out[i])));

    // R7
    a_r7_force_loads: assert property (@(posedge clk) disable iff (!rst_n)
      force_cmd[i] |=> (oflag_w[i] == $past(force_val[i])));

    // R8 sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (miscmp[i] && !(reg_wr && clr_mask[i])) |=> miscmp[i]);

    // R8 clear
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && clr_mask[i] && !(red_en[i] && (oflag_w[i] != oflag_w[P])))
      |=> !miscmp[i]);
  end

endmodule

bind redundant_out_stage ros_checker #(.NCH(NCH)) u_ros_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .red_en    (red_en),
  .inv_out   (inv_out),
  .force_cmd (force_cmd),
  .force_val (force_val),
  .reg_wr    (reg_wr),
  .clr_mask  (clr_mask),
  .oflag_w   (oflag_w),
  .miscmp    (miscmp),
  .pin_out   (pin_out)
);

// File: tb/test_redundant_out_stage.sv
`timescale 1ns/1ps
module test_redundant_out_stage;
  localparam int NCH = 6;
  localparam int SW  = 3;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] flag_in = 0, force_cmd = 0, force_val = 0, red_en = 0;
  logic [NCH-1:0] inv_out = 0, oe_en = 0, inv_in = 0, clr_mask = 0, pin_in = 0;
  logic [NCH*SW-1:0] sec_sel = 0;
  logic reg_wr = 0;
  logic [NCH-1:0] pin_out, pin_oe, miscmp, in_sync;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  redundant_out_stage #(.NCH(NCH)) i_redundant_out_stage (
    .clk(clk), .rst_n(rst_n), .flag_in(flag_in), .force_cmd(force_cmd),
    .force_val(force_val), .red_en(red_en), .inv_out(inv_out), .oe_en(oe_en),
    .inv_in(inv_in), .sec_sel(sec_sel), .reg_wr(reg_wr), .clr_mask(clr_mask),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .miscmp(miscmp),
    .in_sync(in_sync));

  task automatic chk(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_flag[NCH];
  bit m_mc[NCH];
  bit hq[NCH][$];   // newest sample at the front

  function automatic bit m_level(int i);
    return (m_flag[i] && !m_mc[i]) ^ inv_out[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_flag[i] = 0; m_mc[i] = 0;
        hq[i] = {};
        for (int k = 0; k < 5; k++) hq[i].push_back(1'b0);
      end
    end else begin
      bit seen[NCH];
      bit nf[NCH];
      bit nm[NCH];
      for (int j = 0; j < NCH; j++) seen[j] = oe_en[j] ? m_level(j) : pin_in[j];
      for (int i = 0; i < NCH; i++) begin
        int s;
        bit x;
        s = int'(sec_sel[i*SW +: SW]);
        x = ((s < NCH) ? seen[s] : 1'b0) ^ inv_in[i];
        hq[i].push_front(x);
        void'(hq[i].pop_back());
        nf[i] = force_cmd[i] ? force_val[i] : flag_in[i];
        if (red_en[i] && (m_flag[i] != m_flag[i ^ 1])) nm[i] = 1;
        else nm[i] = m_mc[i] && !(reg_wr && clr_mask[i]);
      end
      for (int i = 0; i < NCH; i++) begin
        m_flag[i] = nf[i]; m_mc[i] = nm[i];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NCH-1:0] e_pin, e_mc, e_in;
      for (int i = 0; i < NCH; i++) begin
        e_pin[i] = m_level(i);
        e_mc[i]  = m_mc[i];
        e_in[i]  = (int'(hq[i][2]) + int'(hq[i][3]) + int'(hq[i][4])) >= 2;
      end
      chk("R5 pin_out model", pin_out, e_pin);
      chk("R6 pin_oe model", pin_oe, oe_en);
      chk("R3 miscmp model", miscmp, e_mc);
      chk("R9 in_sync model", in_sync, e_in);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #4;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #4 rst_n = 1;
    tick();
    chk("R10 reset pin_out", pin_out, '0);
    chk("R10 reset miscmp", miscmp, '0);
    chk("R10 reset in_sync", in_sync, '0);
    chk("R10 reset pin_oe", pin_oe, '0);

    // R2: mismatch with check disabled
    flag_in = 6'b000001;
    tick(); tick();
    chk("R2 disabled no set", miscmp, '0);
    chk("R5 flag to pin", pin_out, 6'b000001);
    inv_out = 6'b000001; #1;
    chk("R5 polarity inverts", pin_out, 6'b000000);
    inv_out = 0;

    // R3 / R4
    red_en = 6'b000001;
    tick();
    chk("R3 mismatch sets", miscmp, 6'b000001);
    chk("R4 gated low", pin_out, 6'b000000);
    inv_out = 6'b000001; #1;
    chk("R4 inactive before polarity", pin_out, 6'b000001);
    inv_out = 0;

    // R8: set wins over clear, then sticky, then clear
    reg_wr = 1; clr_mask = 6'b000001;
    tick();
    reg_wr = 0; clr_mask = 0;
    chk("R8 set beats clear", miscmp, 6'b000001);
    flag_in = 6'b000011;
    tick(); tick();
    chk("R8 sticky after match", miscmp, 6'b000001);
    chk("R4 only failed channel gated", pin_out, 6'b000010);
    reg_wr = 1; clr_mask = 6'b000001;
    tick();
    reg_wr = 0; clr_mask = 0;
    chk("R8 write one clears", miscmp, 6'b000000);

    // R1: adjacent but unpaired channels differ
    red_en = 6'b111111; flag_in = 6'b001100;
    tick(); tick();
    chk("R1 no cross-pair compare", miscmp, 6'b000000);

    // R7: force one cycle on channel 4
    force_cmd = 6'b010000; force_val = 6'b010000;
    tick();
    force_cmd = 0; force_val = 0;
    chk("R7 force loads flag", pin_out, 6'b011100);
    tick();
    chk("R3 both partners flag", miscmp, 6'b110000);
    chk("R4 forced channel gated", pin_out, 6'b001100);

    red_en = 0; flag_in = 0; reg_wr = 1; clr_mask = 6'b111111;
    tick();
    reg_wr = 0; clr_mask = 0;
    chk("R8 bulk clear", miscmp, 6'b000000);

    // R6 / R9: channel 0 drives pin 0, everybody reads pin 0
    oe_en = 6'b000001; flag_in = 6'b000001; #1;
    chk("R6 drive enable", pin_oe, 6'b000001);
    repeat (4) tick();
    chk("R9 latency not yet", in_sync, 6'b000000);
    tick();
    chk("R6 driven value seen", in_sync, 6'b111111);
    oe_en = 0; pin_in = 0;
    repeat (3) tick();
    chk("R9 fall not yet", in_sync, 6'b111111);
    tick();
    chk("R6 pin back to input", in_sync, 6'b000000);
    inv_in = 6'b001000;
    repeat (3) tick();
    chk("R9 invert not yet", in_sync, 6'b000000);
    tick();
    chk("R9 input invert", in_sync, 6'b001000);
    inv_in = 0;
    repeat (5) tick();
    pin_in = 6'b000001;
    tick();
    pin_in = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R9 single pulse rejected", in_sync, 6'b000000);
    end

    // random phase
    for (int c = 0; c < 3000; c++) begin
      tick();
      flag_in   = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : flag_in;
      red_en    = ($urandom_range(0, 7) == 0) ? NCH'($urandom) : red_en;
      force_cmd = ($urandom_range(0, 5) == 0) ? NCH'($urandom) : '0;
      force_val = NCH'($urandom);
      inv_out   = ($urandom_range(0, 9) == 0) ? NCH'($urandom) : inv_out;
      oe_en     = ($urandom_range(0, 9) == 0) ? NCH'($urandom) : oe_en;
      inv_in    = ($urandom_range(0, 15) == 0) ? NCH'($urandom) : inv_in;
      pin_in    = ($urandom_range(0, 2) == 0) ? NCH'($urandom) : pin_in;
      reg_wr    = ($urandom_range(0, 4) == 0);
      clr_mask  = NCH'($urandom);
      if ($urandom_range(0, 31) == 0)
        for (int i = 0; i < NCH; i++) sec_sel[i*SW +: SW] = SW'($urandom_range(0, 7));
    end
    tick();
    finish_run();
  end

endmodule